// File: doc/BRIEF.md
# Down-Counting Timer Channel with Deferred Reload

This block is a single timer channel that counts down once per qualified tick of an external tick enable. Software programs it through a small synchronous register bus. A direct load sets the count to a new value on the next tick. A background load changes only the value used at the next reload, so the running count carries on. Reads of either load address return that pending reload value.

The count can run 16 or 32 bits wide. It can run free and wrap to all ones, run periodically and restart from the reload value, or run once and then stop at zero. A prescaler slows the tick stream by 1, 16 or 256. When the count steps from one to zero, a raw interrupt flag is set. Software clears the flag by writing to the clear address. A control bit gates the flag onto the interrupt output.

Top module: `bgload_timer`

## Requirements
- R1: After reset, the load and background-load reads return 0x00000000, the value reads 0xFFFFFFFF, the control reads 0x20, the raw and masked status read 0, and `irq` is 0.
- R2: The byte offsets are 0x00 direct load, 0x04 count value, 0x08 control, 0x0C interrupt clear (reads 0), 0x10 raw status in bit 0, 0x14 masked status in bit 0, and 0x18 background load. Control bits: [7] run, [6] periodic, [5] interrupt enable, [4] reserved (always reads 0), [3:2] prescale code, [1] 32-bit size, [0] one-shot.
- R3: A write to 0x00 sets the reload value at once. The count takes the written value on the first cycle after the write in which `tick_en` is high, even when bit [7] is 0. That load also restarts the prescaler.
- R4: A write to 0x18 changes the reload value only. The count keeps decrementing from where it was.
- R5: If 0x00 and then 0x18 are written before a tick, that tick loads the 0x00 value. Every later reload at zero uses the 0x18 value, and reads of both 0x00 and 0x18 return the 0x18 value.
- R6: The count moves only on a cycle with bit [7] = 1, `tick_en` high and the prescaler at its terminal count. The prescaler advances once per enabled tick. Code 00 gives a terminal count on every tick, 01 on every 16th, 10 on every 256th, and 11 behaves as 00.
- R7: In periodic mode (bit [6] = 1, bit [0] = 0), a decrement step taken at zero loads the reload value.
- R8: In free-running mode, a step taken at zero gives 0x0000FFFF in 16-bit mode and 0xFFFFFFFF in 32-bit mode. In 16-bit mode, a step compares and decrements only the low half and clears the upper half.
- R9: The raw flag is set by a step from 1 to 0. In one-shot mode the count then stays at zero and raises no further interrupt until it is loaded again.
- R10: Any write to 0x0C clears the raw flag. If the flag is set in the same cycle, the set wins.
- R11: The masked status and `irq` both equal the raw flag AND control bit [5].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by the bus and the timer |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Qualifies a timer tick in this cycle |
| reg_wr | input | 1 | Write strobe for the register bus |
| reg_addr | input | ADDR_W | Byte offset of the accessed register |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Combinational read data for `reg_addr` |
| irq | output | 1 | Masked interrupt output |

## Verification
The count is driven with a steady tick and with a random tick. A steady tick tells a periodic reload apart from a free-running wrap. A random tick shows that only qualified ticks move the count or the prescaler. Direct and background loads are written with the tick held low, both alone and as a pair, so the immediate and deferred reload paths can be told apart. The prescale codes 16 and 256 are each run long enough to reach zero. One-shot runs continue past zero to show the count holding there. A closing random mix of writes to every address, tick patterns and control values exercises clears that land on the same cycle as a set, as well as mode changes in the middle of a count.

// File: rtl/tmr_pkg.sv
// Shared types and constants for the timer channel.
// Assumes byte offsets that are aligned to 32-bit words.
package tmr_pkg;

    // Control register layout, MSB first
    typedef struct packed {
        logic       run;
        logic       periodic;
        logic       ie;
        logic       rsvd;
        logic [1:0] pre;
        logic       wide;
        logic       oneshot;
    } tmr_ctrl_t;

    typedef enum logic [1:0] {
        PRE_DIV1   = 2'b00,
        PRE_DIV16  = 2'b01,
        PRE_DIV256 = 2'b10,
        PRE_RSVD   = 2'b11
    } tmr_pre_e;

    localparam logic [7:0] CTRL_RESET = 8'h20;
    localparam logic [7:0] CTRL_WMASK = 8'hEF;

    localparam int OFS_LOAD  = 'h00;
    localparam int OFS_VALUE = 'h04;
    localparam int OFS_CTRL  = 'h08;
    localparam int OFS_CLR   = 'h0C;
    localparam int OFS_RAW   = 'h10;
    localparam int OFS_MSK   = 'h14;
    localparam int OFS_BG    = 'h18;

endpackage

// File: rtl/tmr_regs.sv
// Register storage for the timer channel: control, reload value and a pending direct load.
// Assumes one write per cycle. A direct load is held pending until the next cycle with tick_en high.
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output tmr_ctrl_t         ctrl,
    output logic [DATA_W-1:0] reload_val,
    output logic [DATA_W-1:0] pend_val,
    output logic              load_apply,
    output logic              clr_pulse
);

    logic hit_load;
    logic hit_bg;
    logic hit_ctrl;
    logic hit_clr;
    logic pend_q;

    // Address decode of the writable locations
    always_comb begin
        hit_load = (addr == ADDR_W'(OFS_LOAD));
        hit_bg   = (addr == ADDR_W'(OFS_BG));
        hit_ctrl = (addr == ADDR_W'(OFS_CTRL));
        hit_clr  = (addr == ADDR_W'(OFS_CLR));
    end

    assign load_apply = tick_en & pend_q;
    assign clr_pulse  = wr & hit_clr;

    // Reload value: written by either load path
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_val <= '0;
        end else if (wr && (hit_load || hit_bg)) begin
            reload_val <= wdata;
        end
    end

    // Pending direct load: armed by a write, consumed by the next tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q   <= 1'b0;
            pend_val <= '0;
        end else if (wr && hit_load) begin
            pend_q   <= 1'b1;
            pend_val <= wdata;
        end else if (load_apply) begin
            pend_q   <= 1'b0;
        end
    end

    // Control register with the reserved bit forced to zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= tmr_ctrl_t'(CTRL_RESET);
        end else if (wr && hit_ctrl) begin
            ctrl <= tmr_ctrl_t'(wdata[7:0] & CTRL_WMASK);
        end
    end

endmodule

// File: rtl/tmr_prescale.sv
// Tick prescaler: turns enabled ticks into decrement strobes at a ratio of 1, 16 or 256.
// Assumes PRE_W is even; the middle ratio uses the low half of the counter.
module tmr_prescale
    import tmr_pkg::*;
#(
    parameter int PRE_W = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic       run,
    input  logic       restart,
    input  logic [1:0] code,
    output logic       fire
);

    localparam int MID_W = PRE_W / 2;

    logic [PRE_W-1:0] pre_q;
    logic             adv;
    logic             at_end;

    assign adv = tick_en & run;

    // Terminal-count select for the programmed ratio
    always_comb begin
        case (tmr_pre_e'(code))
            PRE_DIV16:  at_end = &pre_q[MID_W-1:0];
            PRE_DIV256: at_end = &pre_q;
            default:    at_end = 1'b1;
        endcase
    end

    assign fire = adv & at_end;

    // Prescale counter: cleared by a direct load, advanced by each enabled tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (restart) begin
            pre_q <= '0;
        end else if (adv) begin
            pre_q <= pre_q + 1'b1;
        end
    end

endmodule

// File: rtl/tmr_core.sv
// Count register and raw interrupt flag of the timer channel.
// Assumes load_apply and fire come from the same cycle; load_apply has priority over fire.
module tmr_core #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_apply,
    input  logic [DATA_W-1:0] pend_val,
    input  logic              fire,
    input  logic [DATA_W-1:0] reload_val,
    input  logic              wide,
    input  logic              periodic,
    input  logic              oneshot,
    input  logic              clr,
    output logic [DATA_W-1:0] cnt,
    output logic              raw
);

    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] dec_val;
    logic [DATA_W-1:0] wrap_val;
    logic [DATA_W-1:0] cnt_d;
    logic              at_zero;
    logic              at_one;
    logic              hit_zero;

    // Width-dependent compare, decrement and wrap values
    always_comb begin
        if (wide) begin
            at_zero  = (cnt == '0);
            at_one   = (cnt == DATA_W'(1));
            dec_val  = cnt - 1'b1;
            wrap_val = '1;
        end else begin
            at_zero  = (cnt[HALF_W-1:0] == '0);
            at_one   = (cnt[HALF_W-1:0] == HALF_W'(1));
            dec_val  = {{(DATA_W-HALF_W){1'b0}}, cnt[HALF_W-1:0] - 1'b1};
            wrap_val = {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
        end
    end

    // Next count: direct load, then the step at zero, then a plain decrement
    always_comb begin
        cnt_d = cnt;
        if (load_apply) begin
            cnt_d = pend_val;
        end else if (fire) begin
            if (!at_zero) begin
                cnt_d = dec_val;
            end else if (!oneshot) begin
                cnt_d = periodic ? reload_val : wrap_val;
            end
        end
    end

    assign hit_zero = fire & ~load_apply & at_one;

    // Count register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '1;
        end else begin
            cnt <= cnt_d;
        end
    end

    // Raw interrupt flag: a set wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw <= 1'b0;
        end else if (hit_zero) begin
            raw <= 1'b1;
        end else if (clr) begin
            raw <= 1'b0;
        end
    end

endmodule

// File: rtl/bgload_timer.sv
// Top of the timer channel: register bus decode, read mux and interrupt masking.
// Assumes a single clock; timer ticks are qualified by tick_en. Reads are combinational.
module bgload_timer
    import tmr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5,
    parameter int PRE_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);

    tmr_ctrl_t         ctrl;
    logic [DATA_W-1:0] reload_val;
    logic [DATA_W-1:0] pend_val;
    logic [DATA_W-1:0] cnt;
    logic              load_apply;
    logic              clr_pulse;
    logic              fire;
    logic              raw;
    logic              masked;
    logic              ctl_ie;
    logic              ctl_run;
    logic              ctl_one;

    assign ctl_ie  = ctrl.ie;
    assign ctl_run = ctrl.run;
    assign ctl_one = ctrl.oneshot;

    tmr_regs #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_en    (tick_en),
        .wr         (reg_wr),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .ctrl       (ctrl),
        .reload_val (reload_val),
        .pend_val   (pend_val),
        .load_apply (load_apply),
        .clr_pulse  (clr_pulse)
    );

    tmr_prescale #(
        .PRE_W (PRE_W)
    ) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .run     (ctl_run),
        .restart (load_apply),
        .code    (ctrl.pre),
        .fire    (fire)
    );

    tmr_core #(
        .DATA_W (DATA_W)
    ) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_apply (load_apply),
        .pend_val   (pend_val),
        .fire       (fire),
        .reload_val (reload_val),
        .wide       (ctrl.wide),
        .periodic   (ctrl.periodic),
        .oneshot    (ctl_one),
        .clr        (clr_pulse),
        .cnt        (cnt),
        .raw        (raw)
    );

    assign masked = raw & ctl_ie;
    assign irq    = masked;

    // Read mux over the register offsets
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(OFS_LOAD) || reg_addr == ADDR_W'(OFS_BG)) begin
            reg_rdata = reload_val;
        end else if (reg_addr == ADDR_W'(OFS_VALUE)) begin
            reg_rdata = cnt;
        end else if (reg_addr == ADDR_W'(OFS_CTRL)) begin
            reg_rdata = DATA_W'(ctrl);
        end else if (reg_addr == ADDR_W'(OFS_RAW)) begin
            reg_rdata = DATA_W'(raw);
        end else if (reg_addr == ADDR_W'(OFS_MSK)) begin
            reg_rdata = DATA_W'(masked);
        end
    end

endmodule

// File: rtl/bgload_timer_chk.sv
// Property checker for the timer channel, attached to every instance of the top through bind.
// Assumes the internal signal names of bgload_timer.
module bgload_timer_chk #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] cnt,
    input logic              raw,
    input logic              irq,
    input logic              ctl_ie,
    input logic              ctl_run,
    input logic              ctl_one,
    input logic              load_apply,
    input logic              fire
);

    localparam int HALF_W = DATA_W / 2;

    AST_RAW_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(raw) |-> (cnt[HALF_W-1:0] == '0)); // R9

    AST_ONESHOT_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_one && cnt == '0 && !load_apply) |=> (cnt == '0)); // R9

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'('h0C) && !fire) |=> !raw); // R10

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_run && !load_apply) |=> $stable(cnt)); // R6

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_ie |-> !irq); // R11

endmodule

bind bgload_timer bgload_timer_chk #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .cnt        (cnt),
    .raw        (raw),
    .irq        (irq),
    .ctl_ie     (ctl_ie),
    .ctl_run    (ctl_run),
    .ctl_one    (ctl_one),
    .load_apply (load_apply),
    .fire       (fire)
);

// File: tb/test_bgload_timer.sv
`timescale 1ns/1ps
// Bench for bgload_timer: directed register checks plus a per-cycle behavioural model.
module test_bgload_timer;

    localparam int DW = 32;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          tick_en;
    logic          reg_wr;
    logic [AW-1:0] reg_addr;
    logic [DW-1:0] reg_wdata;
    logic [DW-1:0] reg_rdata;
    logic          irq;

    int    n_chk = 0;
    int    n_err = 0;
    bit    chk_on = 0;
    bit    done = 0;
    string cur_tag = "R1";

    // Model state
    logic [31:0] m_cnt, m_rel, m_pval;
    logic [7:0]  m_ctrl;
    bit          m_pend, m_raw;
    int          m_pre;
    bit          s_apply, s_run, s_fire, s_set;
    int          s_div;

    always #2.5 clk = ~clk;

    bgload_timer #(.DATA_W(DW), .ADDR_W(AW), .PRE_W(8)) i_bgload_timer (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] model_rd(logic [AW-1:0] a);
        case (a)
            5'h00, 5'h18: return m_rel;
            5'h04:        return m_cnt;
            5'h08:        return {24'h0, m_ctrl};
            5'h10:        return {31'h0, m_raw};
            5'h14:        return {31'h0, m_raw & m_ctrl[5]};
            default:      return 32'h0;
        endcase
    endfunction

    // Behavioural reference, stepped on every clock edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 32'hFFFF_FFFF; m_rel = 0; m_pval = 0; m_ctrl = 8'h20;
            m_pend = 0; m_raw = 0; m_pre = 0;
        end else begin
            s_apply = tick_en && m_pend;
            s_run   = tick_en && m_ctrl[7];
            case (m_ctrl[3:2])
                2'b01:   s_div = 16;
                2'b10:   s_div = 256;
                default: s_div = 1;
            endcase
            s_fire = s_run && ((m_pre % s_div) == s_div - 1);
            s_set  = 0;
            if (s_apply) m_cnt = m_pval;
            else if (s_fire) begin
                if (m_ctrl[1]) begin
                    if (m_cnt == 0) begin
                        if (!m_ctrl[0]) m_cnt = m_ctrl[6] ? m_rel : 32'hFFFF_FFFF;
                    end else begin
                        if (m_cnt == 1) s_set = 1;
                        m_cnt = m_cnt - 1;
                    end
                end else begin
                    if (m_cnt[15:0] == 0) begin
                        if (!m_ctrl[0]) m_cnt = m_ctrl[6] ? m_rel : 32'h0000_FFFF;
                    end else begin
                        if (m_cnt[15:0] == 1) s_set = 1;
                        m_cnt = {16'h0, m_cnt[15:0] - 16'd1};
                    end
                end
            end
            if (s_apply) m_pre = 0;
            else if (s_run) m_pre = (m_pre + 1) % 256;
            if (s_apply) m_pend = 0;
            if (reg_wr) begin
                case (reg_addr)
                    5'h00: begin m_rel = reg_wdata; m_pend = 1; m_pval = reg_wdata; end
                    5'h18: m_rel = reg_wdata;
                    5'h08: m_ctrl = reg_wdata[7:0] & 8'hEF;
                    5'h0C: if (!s_set) m_raw = 0;
                    default: ;
                endcase
            end
            if (s_set) m_raw = 1;
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (chk_on && !done) begin
            check(reg_rdata == model_rd(reg_addr), cur_tag, reg_rdata, model_rd(reg_addr));
            check(irq == (m_raw & m_ctrl[5]), "R11", {31'h0, irq}, {31'h0, m_raw & m_ctrl[5]});
        end
    end

    task automatic wr(logic [AW-1:0] a, logic [31:0] d);
        @(negedge clk); #1;
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); #1;
        reg_wr = 0; reg_addr = 5'h04;
    endtask

    task automatic rd_chk(logic [AW-1:0] a, logic [31:0] exp, string tag);
        @(negedge clk); #1;
        reg_addr = a;
        #1;
        check(reg_rdata == exp, tag, reg_rdata, exp);
    endtask

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic one_tick();
        @(negedge clk); #1; tick_en = 1;
        @(negedge clk); #1; tick_en = 0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        rst_n = 0; tick_en = 0; reg_wr = 0; reg_addr = 5'h04; reg_wdata = 0;
        repeat (3) @(negedge clk);
        #1 rst_n = 1; chk_on = 1;

        // R1 reset state
        rd_chk(5'h00, 32'h0, "R1");
        rd_chk(5'h04, 32'hFFFF_FFFF, "R1");
        rd_chk(5'h08, 32'h20, "R1");
        rd_chk(5'h10, 32'h0, "R1");
        rd_chk(5'h14, 32'h0, "R1");
        rd_chk(5'h18, 32'h0, "R1");
        check(irq == 0, "R1", {31'h0, irq}, 32'h0);

        // R2 reserved bit reads zero, clear address reads zero
        cur_tag = "R2";
        wr(5'h08, 32'h0000_001C);
        rd_chk(5'h08, 32'h0C, "R2");
        rd_chk(5'h0C, 32'h0, "R2");
        wr(5'h08, 32'h20);

        // R3 direct load waits for a tick, independent of run bit
        cur_tag = "R3";
        wr(5'h00, 32'd5);
        rd_chk(5'h04, 32'hFFFF_FFFF, "R3");
        rd_chk(5'h00, 32'd5, "R3");
        one_tick();
        rd_chk(5'h04, 32'd5, "R3");

        // R4 background load keeps the count running; R7 periodic reload
        cur_tag = "R4";
        wr(5'h08, 32'hE2);
        tick_en = 1;
        wr(5'h00, 32'd10);
        cycles(4);
        wr(5'h18, 32'd3);
        rd_chk(5'h00, 32'd3, "R4");
        rd_chk(5'h18, 32'd3, "R4");
        cur_tag = "R7";
        cycles(30);

        // R5 both loads before a tick
        cur_tag = "R5";
        tick_en = 0;
        wr(5'h00, 32'd7);
        wr(5'h18, 32'd2);
        rd_chk(5'h00, 32'd2, "R5");
        one_tick();
        rd_chk(5'h04, 32'd7, "R5");
        tick_en = 1;
        cycles(25);

        // R6 prescale ratios, disabled run, irregular ticks
        cur_tag = "R6";
        wr(5'h08, 32'hE6);
        wr(5'h00, 32'd20);
        cycles(400);
        wr(5'h08, 32'hEA);
        wr(5'h00, 32'd3);
        cycles(1200);
        wr(5'h08, 32'hEE);
        wr(5'h00, 32'd4);
        cycles(20);
        wr(5'h08, 32'h62);
        cycles(20);
        wr(5'h08, 32'hE6);
        for (int i = 0; i < 300; i++) begin
            @(negedge clk); #1; tick_en = $urandom_range(0, 1);
        end
        tick_en = 1;

        // R8 free-running wrap, both widths
        cur_tag = "R8";
        wr(5'h08, 32'hA0);
        wr(5'h00, 32'd3);
        cycles(20);
        wr(5'h08, 32'hA2);
        wr(5'h00, 32'd2);
        cycles(10);

        // R9 one-shot stops at zero with a single interrupt
        cur_tag = "R9";
        wr(5'h08, 32'hE3);
        wr(5'h00, 32'd4);
        cycles(20);
        rd_chk(5'h04, 32'd0, "R9");
        rd_chk(5'h10, 32'd1, "R9");
        wr(5'h0C, 32'd0);
        cycles(20);
        rd_chk(5'h10, 32'd0, "R9");
        rd_chk(5'h04, 32'd0, "R9");

        // R10 clear write
        cur_tag = "R10";
        wr(5'h08, 32'hE2);
        wr(5'h00, 32'd2);
        cycles(10);
        tick_en = 0;
        rd_chk(5'h10, 32'd1, "R10");
        wr(5'h0C, 32'hDEAD_BEEF);
        rd_chk(5'h10, 32'd0, "R10");

        // R11 masking by interrupt enable
        cur_tag = "R11";
        tick_en = 1;
        wr(5'h08, 32'hC2);
        wr(5'h00, 32'd2);
        cycles(10);
        tick_en = 0;
        rd_chk(5'h10, 32'd1, "R11");
        rd_chk(5'h14, 32'd0, "R11");
        check(irq == 0, "R11", {31'h0, irq}, 32'h0);
        wr(5'h08, 32'hE2);
        rd_chk(5'h14, 32'd1, "R11");

        // Random mix, including clears that collide with sets (R10)
        cur_tag = "R10";
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk); #1;
            tick_en = ($urandom_range(0, 3) != 0);
            reg_wr  = 0;
            reg_addr = 5'h04;
            if ($urandom_range(0, 9) == 0) begin
                reg_wr = 1;
                case ($urandom_range(0, 4))
                    0: begin reg_addr = 5'h00; reg_wdata = $urandom_range(0, 6); end
                    1: begin reg_addr = 5'h18; reg_wdata = $urandom_range(0, 6); end
                    2: begin reg_addr = 5'h08; reg_wdata = {24'h0, 2'b11, 1'($urandom_range(0, 1)),
                                                           1'b0, 2'b00, 2'($urandom_range(0, 3))}; end
                    default: begin reg_addr = 5'h0C; reg_wdata = $urandom; end
                endcase
            end else if ($urandom_range(0, 3) == 0) begin
                reg_addr = 5'($urandom_range(0, 6) * 4);
            end
        end
        @(negedge clk); #1; reg_wr = 0; reg_addr = 5'h04;
        cycles(4);
        finish_run();
    end

endmodule